// File: doc/BRIEF.md
# Paged Program Sequencer with Return Stack

This block produces the fetch address of a small 4-bit processor. The address is ten bits wide: a four-bit page selecting one of sixteen pages and a six-bit in-page offset selecting one of sixty-four words. Sequential flow never moves the offset in binary order. It steps it through a six-bit polynomial (linear feedback) sequence, so code is laid out in that visiting order. Sequential flow never leaves the current page.

The instruction decoder tells the block what the retiring instruction does. `advance` marks the cycle in which an instruction retires. Alongside it, the decoder raises one of the flow controls: in-page jump, long jump, in-page call, long call, return, or a request to skip the next instruction. Calls save the next sequential address on a two-entry return stack. Returns take it back.

A pending skip raises `squash`. The next retiring instruction then acts as a no-op: it only steps the counter, and its controls are ignored. Reset sets the address, the stack and the skip state to zero.

Top module: `pageSeqTop`

## Requirements
- R1: After reset, `fetchAddr` is 000h, `squash` is 0 and both stack entries hold 000h.
- R2: With `advance` high and no flow control, the page (bits 9:6) is kept. The offset s (bits 5:0) becomes {s[4:0], f}, where f = s[5] XOR s[4] XOR (s[4:0]==0). From 0, sixty-four steps visit every offset once and return to 0.
- R3: While `advance` is low, `fetchAddr`, `squash` and the stack do not change, whatever the other inputs carry.
- R4: An in-page jump (`jmpEn`) replaces bits 5:0 with `targetAddr[5:0]` and keeps the page.
- R5: A long jump (`jmplEn`) loads all ten bits of `targetAddr`.
- R6: An in-page call (`calEn`) or a long call (`callEn`) pushes the next sequential address (current page, stepped offset). It then loads the target: the offset only for `calEn`, all ten bits for `callEn`.
- R7: A push moves entry 1 into entry 2. After three calls in a row, only the two most recent return addresses remain.
- R8: A return (`retEn`) loads entry 1 into `fetchAddr` and copies entry 2 into entry 1, while entry 2 keeps its value. Repeated returns past the depth keep producing the entry-2 address.
- R9: `skipSet` on a retiring, non-squashed instruction raises `squash` for the next instruction. That next retiring instruction only steps the counter, ignores all its flow controls and its own `skipSet`, and clears `squash`.
- R10: When several controls arrive together, the priority is: `retEn`, then `callEn`, then `jmplEn`, then `calEn`, then `jmpEn`.
- R11: A squashed call or return leaves both stack entries unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| advance | input | 1 | Current instruction retires this cycle |
| jmpEn | input | 1 | In-page jump |
| jmplEn | input | 1 | Long jump |
| calEn | input | 1 | In-page call |
| callEn | input | 1 | Long call |
| retEn | input | 1 | Return |
| skipSet | input | 1 | Skip the next instruction |
| targetAddr | input | 10 | Jump or call target |
| fetchAddr | output | 10 | Address of the instruction being fetched |
| squash | output | 1 | Current instruction executes as a no-op |

## Verification
The hardest state to reach from the ports is a stack that has overflowed and then been drained past its depth. Entry 2 is invisible until two returns have passed, and its duplication shows only on a third return. The bench therefore jumps to three distinct long addresses and calls from each one. It then returns three times and compares each landing address with the return addresses it computed. A squashed call is placed between a known push and a return, so that any change it made to the stack would surface in the return address.

// File: rtl/seqPkg.sv
package seqPkg;
  typedef struct packed {
    logic hold;
    logic loadLow;
    logic loadFull;
    logic push;
    logic pop;
  } seqStrobe_t;
endpackage

// File: rtl/seqStep.sv
module seqStep #(
  parameter int LOW_W = 6,
  parameter logic [LOW_W-1:0] TAP_MASK = 6'b110000
) (
  input  logic [LOW_W-1:0] cur,
  output logic [LOW_W-1:0] nxt
);
  logic lowerZero;
  logic fb;
  always_comb begin
    lowerZero = (cur[LOW_W-2:0] == '0);
    fb = (^(cur & TAP_MASK)) ^ lowerZero;
    nxt = {cur[LOW_W-2:0], fb};
  end
endmodule

// File: rtl/seqCtrl.sv
module seqCtrl
  import seqPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       advance,
  input  logic       jmpEn,
  input  logic       jmplEn,
  input  logic       calEn,
  input  logic       callEn,
  input  logic       retEn,
  input  logic       skipSet,
  output seqStrobe_t strobe,
  output logic       skipQ
);
  always_ff @(posedge clk) begin
    if (!rstN) skipQ <= 1'b0;
    else if (advance) skipQ <= skipQ ? 1'b0 : skipSet;
  end

  always_comb begin
    strobe = '0;
    if (!advance) begin
      strobe.hold = 1'b1;
    end else if (!skipQ) begin
      if (retEn) begin
        strobe.pop = 1'b1;
      end else if (callEn) begin
        strobe.push = 1'b1;
        strobe.loadFull = 1'b1;
      end else if (jmplEn) begin
        strobe.loadFull = 1'b1;
      end else if (calEn) begin
        strobe.push = 1'b1;
        strobe.loadLow = 1'b1;
      end else if (jmpEn) begin
        strobe.loadLow = 1'b1;
      end
    end
  end
endmodule

// File: rtl/seqPath.sv
module seqPath
  import seqPkg::*;
#(
  parameter int PAGE_W = 4,
  parameter int LOW_W = 6,
  parameter int DEPTH = 2,
  parameter logic [LOW_W-1:0] TAP_MASK = 6'b110000,
  localparam int ADDR_W = PAGE_W + LOW_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqStrobe_t        strobe,
  input  logic [ADDR_W-1:0] targetAddr,
  output logic [ADDR_W-1:0] pcQ
);
  logic [LOW_W-1:0]  stepLow;
  logic [ADDR_W-1:0] seqAddr;
  logic [ADDR_W-1:0] stk [DEPTH];
  logic [ADDR_W-1:0] pcNext;

  seqStep #(.LOW_W(LOW_W), .TAP_MASK(TAP_MASK)) u_step (
    .cur(pcQ[LOW_W-1:0]),
    .nxt(stepLow)
  );

  assign seqAddr = {pcQ[ADDR_W-1:LOW_W], stepLow};

  always_comb begin
    if (strobe.hold) pcNext = pcQ;
    else if (strobe.pop) pcNext = stk[0];
    else if (strobe.loadFull) pcNext = targetAddr;
    else if (strobe.loadLow) pcNext = {pcQ[ADDR_W-1:LOW_W], targetAddr[LOW_W-1:0]};
    else pcNext = seqAddr;
  end

  always_ff @(posedge clk) begin
    if (!rstN) pcQ <= '0;
    else pcQ <= pcNext;
  end

  for (genvar i = 0; i < DEPTH; i++) begin : g_lvl
    if (i == 0) begin : g_top
      always_ff @(posedge clk) begin
        if (!rstN) stk[i] <= '0;
        else if (strobe.push) stk[i] <= seqAddr;
        else if (strobe.pop) stk[i] <= stk[i+1];
      end
    end else if (i == DEPTH - 1) begin : g_bottom
      always_ff @(posedge clk) begin
        if (!rstN) stk[i] <= '0;
        else if (strobe.push) stk[i] <= stk[i-1];
      end
    end else begin : g_mid
      always_ff @(posedge clk) begin
        if (!rstN) stk[i] <= '0;
        else if (strobe.push) stk[i] <= stk[i-1];
        else if (strobe.pop) stk[i] <= stk[i+1];
      end
    end
  end
endmodule

// File: rtl/pageSeqTop.sv
module pageSeqTop
  import seqPkg::*;
#(
  parameter int PAGE_W = 4,
  parameter int LOW_W = 6,
  parameter int DEPTH = 2,
  localparam int ADDR_W = PAGE_W + LOW_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              advance,
  input  logic              jmpEn,
  input  logic              jmplEn,
  input  logic              calEn,
  input  logic              callEn,
  input  logic              retEn,
  input  logic              skipSet,
  input  logic [ADDR_W-1:0] targetAddr,
  output logic [ADDR_W-1:0] fetchAddr,
  output logic              squash
);
  seqStrobe_t strobe;

  seqCtrl u_ctrl (
    .clk(clk), .rstN(rstN), .advance(advance),
    .jmpEn(jmpEn), .jmplEn(jmplEn), .calEn(calEn), .callEn(callEn),
    .retEn(retEn), .skipSet(skipSet),
    .strobe(strobe), .skipQ(squash)
  );

  seqPath #(.PAGE_W(PAGE_W), .LOW_W(LOW_W), .DEPTH(DEPTH)) u_path (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .targetAddr(targetAddr), .pcQ(fetchAddr)
  );
endmodule

// File: rtl/pageSeqChecker.sv
module pageSeqChecker #(
  parameter int ADDR_W = 10,
  parameter int LOW_W = 6
) (
  input logic              clk,
  input logic              rstN,
  input logic              advance,
  input logic              jmpEn,
  input logic              jmplEn,
  input logic              calEn,
  input logic              callEn,
  input logic              retEn,
  input logic              skipSet,
  input logic [ADDR_W-1:0] targetAddr,
  input logic [ADDR_W-1:0] fetchAddr,
  input logic              squash
);
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    !advance |=> $stable(fetchAddr) && $stable(squash)); // R3

  AST_PAGE_KEPT: assert property (@(posedge clk) disable iff (!rstN)
    advance && (squash || !(retEn || callEn || jmplEn)) |=>
      fetchAddr[ADDR_W-1:LOW_W] == $past(fetchAddr[ADDR_W-1:LOW_W])); // R2

  AST_LONG_JUMP: assert property (@(posedge clk) disable iff (!rstN)
    advance && !squash && jmplEn && !retEn && !callEn |=>
      fetchAddr == $past(targetAddr)); // R5

  AST_SKIP_RAISE: assert property (@(posedge clk) disable iff (!rstN)
    advance && !squash && skipSet |=> squash); // R9

  AST_SKIP_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    advance && squash |=> !squash); // R9

  AST_SQUASH_STEPS: assert property (@(posedge clk) disable iff (!rstN)
    advance && squash |=>
      fetchAddr[LOW_W-1:0] != $past(fetchAddr[LOW_W-1:0])); // R9
endmodule

bind pageSeqTop pageSeqChecker #(.ADDR_W(ADDR_W), .LOW_W(LOW_W)) u_chk (
  .clk(clk), .rstN(rstN), .advance(advance),
  .jmpEn(jmpEn), .jmplEn(jmplEn), .calEn(calEn), .callEn(callEn),
  .retEn(retEn), .skipSet(skipSet), .targetAddr(targetAddr),
  .fetchAddr(fetchAddr), .squash(squash)
);

// File: tb/test_pageSeqTop.sv
module test_pageSeqTop;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic advance = 1'b0, jmpEn = 1'b0, jmplEn = 1'b0, calEn = 1'b0;
  logic callEn = 1'b0, retEn = 1'b0, skipSet = 1'b0;
  logic [9:0] targetAddr = '0;
  logic [9:0] fetchAddr;
  logic squash;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pageSeqTop i_pageSeqTop (
    .clk(clk), .rstN(rstN), .advance(advance),
    .jmpEn(jmpEn), .jmplEn(jmplEn), .calEn(calEn), .callEn(callEn),
    .retEn(retEn), .skipSet(skipSet), .targetAddr(targetAddr),
    .fetchAddr(fetchAddr), .squash(squash)
  );

  function automatic logic [5:0] stepOff(input logic [5:0] s);
    logic f;
    f = s[5] ^ s[4] ^ (s[4:0] == 5'd0);
    return {s[4:0], f};
  endfunction

  function automatic logic [9:0] nextSeq(input logic [9:0] a);
    return {a[9:6], stepOff(a[5:0])};
  endfunction

  task automatic chk(input string req, input logic [9:0] act, input logic [9:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // one retire cycle: inputs driven at a falling edge, outputs sampled at the next one
  task automatic op(input logic adv, input logic j, input logic jl, input logic c,
                    input logic cl, input logic r, input logic sk, input logic [9:0] tgt);
    advance = adv; jmpEn = j; jmplEn = jl; calEn = c; callEn = cl;
    retEn = r; skipSet = sk; targetAddr = tgt;
    @(negedge clk);
    advance = 0; jmpEn = 0; jmplEn = 0; calEn = 0; callEn = 0;
    retEn = 0; skipSet = 0; targetAddr = '0;
  endtask

  task automatic gotoAddr(input logic [9:0] a);
    op(1, 0, 1, 0, 0, 0, 0, a);
  endtask

  task automatic tReset();
    chk("R1 addr", fetchAddr, 10'h000);
    chk("R1 squash", {9'd0, squash}, 10'h000);
    op(1, 0, 0, 0, 0, 1, 0, 10'h155);
    chk("R1 stack1 zero", fetchAddr, 10'h000);
    op(1, 0, 0, 0, 0, 1, 0, 10'h155);
    chk("R1 stack2 zero", fetchAddr, 10'h000);
  endtask

  task automatic tStep();
    logic [63:0] seen;
    logic [9:0] exp;
    seen = '0;
    gotoAddr(10'h0C0);
    exp = 10'h0C0;
    for (int i = 0; i < 64; i++) begin
      seen[fetchAddr[5:0]] = 1'b1;
      op(1, 0, 0, 0, 0, 0, 0, 10'h3FF);
      exp = nextSeq(exp);
      if (fetchAddr !== exp) chk("R2 step", fetchAddr, exp);
    end
    chk("R2 back to start", fetchAddr, 10'h0C0);
    chk("R2 all offsets", {9'd0, &seen}, 10'h001);
    chk("R2 zero successor", {4'd0, stepOff(6'h00)}, 10'h001);
  endtask

  task automatic tHold();
    gotoAddr(10'h2A7);
    op(0, 1, 1, 1, 1, 1, 1, 10'h111);
    chk("R3 addr held", fetchAddr, 10'h2A7);
    chk("R3 squash held", {9'd0, squash}, 10'h000);
    op(1, 0, 0, 0, 0, 0, 1, 10'h000);
    op(0, 0, 0, 0, 0, 0, 0, 10'h000);
    chk("R3 squash stays", {9'd0, squash}, 10'h001);
    op(1, 0, 0, 0, 0, 0, 0, 10'h000);
  endtask

  task automatic tJumps();
    gotoAddr(10'h2D5);
    chk("R5 long jump", fetchAddr, 10'h2D5);
    op(1, 1, 0, 0, 0, 0, 0, 10'h3AA);
    chk("R4 in-page jump", fetchAddr, {4'hB, 6'h2A});
  endtask

  task automatic tCalls();
    logic [9:0] r1;
    gotoAddr(10'h1C3);
    r1 = nextSeq(10'h1C3);
    op(1, 0, 0, 1, 0, 0, 0, 10'h3D1);
    chk("R6 in-page call target", fetchAddr, {4'h7, 6'h11});
    op(1, 0, 0, 0, 0, 1, 0, 10'h000);
    chk("R6 R8 return from call", fetchAddr, r1);
    gotoAddr(10'h081);
    op(1, 0, 0, 0, 1, 0, 0, 10'h3E5);
    chk("R6 long call target", fetchAddr, 10'h3E5);
    op(1, 0, 0, 0, 0, 1, 0, 10'h000);
    chk("R6 long call return", fetchAddr, nextSeq(10'h081));
  endtask

  task automatic tDepth();
    logic [9:0] a [3];
    a[0] = 10'h041; a[1] = 10'h182; a[2] = 10'h30F;
    for (int i = 0; i < 3; i++) begin
      gotoAddr(a[i]);
      op(1, 0, 0, 0, 1, 0, 0, 10'h200);
    end
    op(1, 0, 0, 0, 0, 1, 0, 10'h000);
    chk("R7 newest return", fetchAddr, nextSeq(a[2]));
    op(1, 0, 0, 0, 0, 1, 0, 10'h000);
    chk("R7 second return", fetchAddr, nextSeq(a[1]));
    op(1, 0, 0, 0, 0, 1, 0, 10'h000);
    chk("R8 duplicated level 2", fetchAddr, nextSeq(a[1]));
  endtask

  task automatic tSkip();
    gotoAddr(10'h105);
    op(1, 0, 0, 0, 0, 0, 1, 10'h000);
    chk("R9 squash raised", {9'd0, squash}, 10'h001);
    chk("R9 skip instr steps", fetchAddr, nextSeq(10'h105));
    op(1, 0, 1, 0, 0, 0, 1, 10'h3C0);
    chk("R9 squashed jump ignored", fetchAddr, nextSeq(nextSeq(10'h105)));
    chk("R9 squash cleared, own skip ignored", {9'd0, squash}, 10'h000);
  endtask

  task automatic tSquashCall();
    gotoAddr(10'h222);
    op(1, 0, 0, 0, 1, 0, 0, 10'h050);
    op(1, 0, 0, 0, 0, 0, 1, 10'h000);
    op(1, 0, 0, 1, 1, 0, 0, 10'h3FF);
    chk("R11 squashed call steps", fetchAddr, nextSeq(nextSeq(10'h050)));
    op(1, 0, 0, 0, 0, 0, 1, 10'h000);
    op(1, 0, 0, 0, 0, 1, 0, 10'h000);
    op(1, 0, 0, 0, 0, 1, 0, 10'h000);
    chk("R11 stack unchanged", fetchAddr, nextSeq(10'h222));
  endtask

  task automatic tPriority();
    logic [9:0] here;
    gotoAddr(10'h3C4);
    op(1, 0, 0, 0, 1, 0, 0, 10'h010);
    op(1, 1, 1, 1, 1, 1, 0, 10'h155);
    chk("R10 return wins", fetchAddr, nextSeq(10'h3C4));
    here = fetchAddr;
    op(1, 1, 1, 1, 1, 0, 0, 10'h2A9);
    chk("R10 long call over long jump", fetchAddr, 10'h2A9);
    op(1, 0, 0, 0, 0, 1, 0, 10'h000);
    chk("R10 long call pushed", fetchAddr, nextSeq(here));
    op(1, 1, 0, 1, 0, 0, 0, 10'h01C);
    chk("R10 cal over jmp", fetchAddr, {fetchAddr[9:6], 6'h1C});
    op(1, 0, 0, 0, 0, 1, 0, 10'h000);
    chk("R10 cal pushed", fetchAddr, nextSeq(nextSeq(here)));
    op(1, 1, 1, 1, 0, 0, 0, 10'h18E);
    chk("R10 long jump over cal", fetchAddr, 10'h18E);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    tReset();
    tStep();
    tHold();
    tJumps();
    tCalls();
    tDepth();
    tSkip();
    tSquashCall();
    tPriority();
    done = 1'b1;
  end

  initial begin
    int cyc;
    cyc = 0;
    while (!done && cyc < 20000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=%0d expected=done", cyc);
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule